// File: doc/BRIEF.md
# Rotating Triple Reference Buffer Controller

This controller coordinates three reference-pixel SRAM banks used by three parties: an integer motion-estimation stage, a fractional motion-estimation stage, and a loader that fills banks from external memory. Each bank always holds exactly one of three roles. When all three parties report that the current macroblock step is complete, the roles rotate.

On each rotation, the bank the integer search just used passes to the fractional search. The bank the fractional search used is handed to the loader. The bank that was just filled goes to the integer search. Because only the roles move, reference data is never copied between stages.

With each rotation the controller also passes the finished macroblock's motion vector to the fractional stage. It then decides whether the fractional stage can work from the bank it has just received. This is only possible when both vector components lie inside the level-0 window, shrunk by the interpolation margin. If either component falls outside, the controller raises a refetch request and holds the fractional start until the request is acknowledged. Two counters record how many macroblocks reused their bank and how many needed a refetch.

Top module: `ref_bank_rotator`

## Requirements
- R1: After reset the integer-search bank is 0, the fractional-search bank is 1 and the load bank is 2. All start, request and reuse outputs are low, and both counters are zero.
- R2: On each rotation the new fractional bank is the old integer bank, the new load bank is the old fractional bank, and the new integer bank is the old load bank. The three bank indices are always distinct and below 3.
- R3: A rotation takes place only when all three done pulses (ime_done, fme_done, load_done) have been seen since the previous rotation and no check or refetch is pending. Until then, every bank index holds its value.
- R4: In the cycle the new assignment appears, ime_start and load_req are each high for exactly one cycle.
- R5: The motion vector is captured when ime_done is high. It appears on fme_mv_x and fme_mv_y in the cycle the new assignment appears.
- R6: fme_reuse is updated in the rotation cycle. It is 1 only when both signed 8-bit components lie in [L0_MIN+TAP_MARGIN, L0_MAX-TAP_MARGIN]. With the default parameters this range is [-13, 12].
- R7: When fme_reuse is 1, fme_start pulses for one cycle, one cycle after the rotation, and refetch_req stays low.
- R8: When fme_reuse is 0, refetch_req rises one cycle after the rotation and stays high until refetch_ack is seen. fme_start then pulses in the following cycle. No rotation takes place while refetch_req is high.
- R9: reuse_count increments once per reuse decision and refetch_count increments once per refetch decision, each in the cycle the decision takes effect.
- R10: refetch_ack has no effect while refetch_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ime_done | input | 1 | Pulse: integer search has finished the current macroblock |
| fme_done | input | 1 | Pulse: fractional search has finished its macroblock |
| load_done | input | 1 | Pulse: external load into the load bank is complete |
| ime_mv_x | input | 8 | Signed final vector x component, taken when ime_done is high |
| ime_mv_y | input | 8 | Signed final vector y component, taken when ime_done is high |
| refetch_ack | input | 1 | Refetch data is available to the fractional stage |
| ime_bank | output | 2 | Bank index serving integer search |
| fme_bank | output | 2 | Bank index serving fractional search |
| load_bank | output | 2 | Bank index being filled by the loader |
| ime_start | output | 1 | One-cycle start for the integer stage on the new bank |
| load_req | output | 1 | One-cycle request to fill the new load bank |
| fme_start | output | 1 | One-cycle start for the fractional stage |
| fme_reuse | output | 1 | 1 when the fractional stage may use its bank as is |
| fme_mv_x | output | 8 | Vector x handed to the fractional stage and the refetch |
| fme_mv_y | output | 8 | Vector y handed to the fractional stage and the refetch |
| refetch_req | output | 1 | Separate fetch needed; held until refetch_ack |
| reuse_count | output | CNT_W | Macroblocks that reused their bank |
| refetch_count | output | CNT_W | Macroblocks that needed a refetch |

## Verification
The embedded properties check the following on every cycle:
- the three bank indices stay distinct;
- the role handover follows the rotation on each step;
- the banks hold steady between steps;
- integer start and load request are single pulses;
- a reuse verdict never accompanies a vector outside the shrunk window;
- fme_start and refetch_req are never high together;
- a refetch request holds until acknowledged;
- exactly one counter moves per decision.

Only the bench scenarios can show the following:
- the exact bank sequence over many steps;
- that a missing done pulse stalls the rotation indefinitely;
- that a stray acknowledge is ignored;
- that completions arriving during a refetch are held and then applied once the refetch is acknowledged;
- the verdict at the window edges.

// File: rtl/rbr_pkg.sv
package rbr_pkg;

  localparam int NUM_BANKS = 3;

  typedef logic [1:0]        bank_idx_t;
  typedef logic signed [7:0] mv_comp_t;

  // A component is usable from the held bank when it stays a full
  // interpolation margin away from either edge of the stored window.
  function automatic logic comp_in_window(mv_comp_t c, int lo, int hi, int margin);
    return (int'(c) >= lo + margin) && (int'(c) <= hi - margin);
  endfunction

  function automatic logic vec_in_window(mv_comp_t x, mv_comp_t y, int lo, int hi, int margin);
    return comp_in_window(x, lo, hi, margin) && comp_in_window(y, lo, hi, margin);
  endfunction

endpackage

// File: rtl/rbr_role_rotator.sv
module rbr_role_rotator
  import rbr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step,
  output bank_idx_t ime_bank,
  output bank_idx_t fme_bank,
  output bank_idx_t load_bank,
  output logic      ime_start,
  output logic      load_req
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ime_bank  <= 2'd0;
      fme_bank  <= 2'd1;
      load_bank <= 2'd2;
      ime_start <= 1'b0;
      load_req  <= 1'b0;
    end else begin
      ime_start <= step;
      load_req  <= step;
      if (step) begin
        fme_bank  <= ime_bank;
        load_bank <= fme_bank;
        ime_bank  <= load_bank;
      end
    end
  end

  assert_roles_distinct_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ime_bank != fme_bank) && (fme_bank != load_bank) && (ime_bank != load_bank)
    && (ime_bank < 2'd3) && (fme_bank < 2'd3) && (load_bank < 2'd3));

  assert_handover_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (fme_bank == $past(ime_bank)) && (load_bank == $past(fme_bank)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(ime_bank) && $stable(fme_bank) && $stable(load_bank));

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ime_start |=> !ime_start && !load_req);

endmodule

// File: rtl/rbr_reuse_check.sv
module rbr_reuse_check
  import rbr_pkg::*;
#(
  parameter int L0_MIN     = -16,
  parameter int L0_MAX     = 15,
  parameter int TAP_MARGIN = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     capture,
  input  mv_comp_t mv_in_x,
  input  mv_comp_t mv_in_y,
  input  logic     step,
  output mv_comp_t fme_mv_x,
  output mv_comp_t fme_mv_y,
  output logic     reuse,
  output logic     check_valid
);

  localparam int LO_OK = L0_MIN + TAP_MARGIN;
  localparam int HI_OK = L0_MAX - TAP_MARGIN;

  mv_comp_t hold_x, hold_y;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_x      <= '0;
      hold_y      <= '0;
      fme_mv_x    <= '0;
      fme_mv_y    <= '0;
      reuse       <= 1'b0;
      check_valid <= 1'b0;
    end else begin
      if (capture) begin
        hold_x <= mv_in_x;
        hold_y <= mv_in_y;
      end
      check_valid <= step;
      if (step) begin
        fme_mv_x <= hold_x;
        fme_mv_y <= hold_y;
        reuse    <= vec_in_window(hold_x, hold_y, L0_MIN, L0_MAX, TAP_MARGIN);
      end
    end
  end

  assert_reuse_inside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (check_valid && reuse) |-> (int'(fme_mv_x) >= LO_OK) && (int'(fme_mv_x) <= HI_OK)
                            && (int'(fme_mv_y) >= LO_OK) && (int'(fme_mv_y) <= HI_OK));

  assert_verdict_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(reuse) && $stable(fme_mv_x) && $stable(fme_mv_y));

endmodule

// File: rtl/rbr_fme_launch.sv
module rbr_fme_launch #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             check_valid,
  input  logic             reuse,
  input  logic             refetch_ack,
  output logic             fme_start,
  output logic             refetch_req,
  output logic             busy,
  output logic [CNT_W-1:0] reuse_cnt,
  output logic [CNT_W-1:0] refetch_cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fme_start   <= 1'b0;
      refetch_req <= 1'b0;
      reuse_cnt   <= '0;
      refetch_cnt <= '0;
    end else begin
      fme_start <= 1'b0;
      if (check_valid) begin
        if (reuse) begin
          fme_start <= 1'b1;
          reuse_cnt <= reuse_cnt + 1'b1;
        end else begin
          refetch_req <= 1'b1;
          refetch_cnt <= refetch_cnt + 1'b1;
        end
      end else if (refetch_req && refetch_ack) begin
        refetch_req <= 1'b0;
        fme_start   <= 1'b1;
      end
    end
  end

  assign busy = check_valid | refetch_req;

  assert_start_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fme_start && refetch_req));

  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (refetch_req && !refetch_ack) |=> refetch_req);

  assert_one_counter_R9: assert property (@(posedge clk) disable iff (!rst_n)
    check_valid |=> ((reuse_cnt != $past(reuse_cnt)) != (refetch_cnt != $past(refetch_cnt))));

  assert_stray_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!refetch_req && !check_valid) |=> !fme_start);

endmodule

// File: rtl/ref_bank_rotator.sv
module ref_bank_rotator
  import rbr_pkg::*;
#(
  parameter int L0_MIN     = -16,
  parameter int L0_MAX     = 15,
  parameter int TAP_MARGIN = 3,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ime_done,
  input  logic              fme_done,
  input  logic              load_done,
  input  logic signed [7:0] ime_mv_x,
  input  logic signed [7:0] ime_mv_y,
  input  logic              refetch_ack,
  output logic [1:0]        ime_bank,
  output logic [1:0]        fme_bank,
  output logic [1:0]        load_bank,
  output logic              ime_start,
  output logic              load_req,
  output logic              fme_start,
  output logic              fme_reuse,
  output logic signed [7:0] fme_mv_x,
  output logic signed [7:0] fme_mv_y,
  output logic              refetch_req,
  output logic [CNT_W-1:0]  reuse_count,
  output logic [CNT_W-1:0]  refetch_count
);

  logic seen_ime, seen_fme, seen_load;
  logic step, busy, check_valid;

  // Sticky completion flags: a done pulse survives until the step it enables.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_ime  <= 1'b0;
      seen_fme  <= 1'b0;
      seen_load <= 1'b0;
    end else begin
      seen_ime  <= (seen_ime  & ~step) | ime_done;
      seen_fme  <= (seen_fme  & ~step) | fme_done;
      seen_load <= (seen_load & ~step) | load_done;
    end
  end

  assign step = seen_ime & seen_fme & seen_load & ~busy;

  rbr_role_rotator u_rot (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .ime_bank  (ime_bank),
    .fme_bank  (fme_bank),
    .load_bank (load_bank),
    .ime_start (ime_start),
    .load_req  (load_req)
  );

  rbr_reuse_check #(
    .L0_MIN     (L0_MIN),
    .L0_MAX     (L0_MAX),
    .TAP_MARGIN (TAP_MARGIN)
  ) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture     (ime_done),
    .mv_in_x     (ime_mv_x),
    .mv_in_y     (ime_mv_y),
    .step        (step),
    .fme_mv_x    (fme_mv_x),
    .fme_mv_y    (fme_mv_y),
    .reuse       (fme_reuse),
    .check_valid (check_valid)
  );

  rbr_fme_launch #(.CNT_W(CNT_W)) u_launch (
    .clk         (clk),
    .rst_n       (rst_n),
    .check_valid (check_valid),
    .reuse       (fme_reuse),
    .refetch_ack (refetch_ack),
    .fme_start   (fme_start),
    .refetch_req (refetch_req),
    .busy        (busy),
    .reuse_cnt   (reuse_count),
    .refetch_cnt (refetch_count)
  );

  assert_no_step_in_refetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    refetch_req |=> !ime_start);

  assert_step_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ime_start && load_req);

endmodule

// File: tb/tb_ref_bank_rotator.sv
module tb_ref_bank_rotator;

  logic clk = 1'b0;
  logic rst_n;
  logic ime_done, fme_done, load_done, refetch_ack;
  logic signed [7:0] ime_mv_x, ime_mv_y;
  logic [1:0] ime_bank, fme_bank, load_bank;
  logic ime_start, load_req, fme_start, fme_reuse, refetch_req;
  logic signed [7:0] fme_mv_x, fme_mv_y;
  logic [15:0] reuse_count, refetch_count;

  always #2.5 clk = ~clk;

  ref_bank_rotator dut (
    .clk(clk), .rst_n(rst_n), .ime_done(ime_done), .fme_done(fme_done),
    .load_done(load_done), .ime_mv_x(ime_mv_x), .ime_mv_y(ime_mv_y),
    .refetch_ack(refetch_ack), .ime_bank(ime_bank), .fme_bank(fme_bank),
    .load_bank(load_bank), .ime_start(ime_start), .load_req(load_req),
    .fme_start(fme_start), .fme_reuse(fme_reuse), .fme_mv_x(fme_mv_x),
    .fme_mv_y(fme_mv_y), .refetch_req(refetch_req), .reuse_count(reuse_count),
    .refetch_count(refetch_count)
  );

  int checks = 0;
  int errors = 0;
  int steps  = 0;
  int n_reuse = 0;
  int n_refetch = 0;

  // {x, y, expected reuse}; the window is [-13, 12] for defaults.
  localparam logic [16:0] VEC [0:7] = '{
    {8'sd0,    8'sd0,    1'b1},
    {8'sd12,  -8'sd13,   1'b1},
    {8'sd13,   8'sd0,    1'b0},
    {8'sd0,   -8'sd14,   1'b0},
    {-8'sd128, 8'sd127,  1'b0},
    {8'sd5,   -8'sd7,    1'b1},
    {-8'sd13,  8'sd12,   1'b1},
    {8'sd127, -8'sd128,  1'b0}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_banks(input string req);
    int ei;
    ei = (3 - (steps % 3)) % 3;
    chk(ime_bank == ei, req, ime_bank, ei);
    chk(fme_bank == (ei + 1) % 3, req, fme_bank, (ei + 1) % 3);
    chk(load_bank == (ei + 2) % 3, req, load_bank, (ei + 2) % 3);
  endtask

  task automatic pulse_done(input logic i, input logic f, input logic l,
                            input logic signed [7:0] x, input logic signed [7:0] y);
    ime_done = i; fme_done = f; load_done = l; ime_mv_x = x; ime_mv_y = y;
    tick();
    ime_done = 0; fme_done = 0; load_done = 0;
  endtask

  // Verdict path after the rotation cycle has been sampled.
  task automatic finish_macroblock(input logic exp_reuse);
    tick();
    if (exp_reuse) begin
      n_reuse++;
      chk(fme_start == 1'b1, "R7 fme_start", fme_start, 1);
      chk(refetch_req == 1'b0, "R7 no refetch", refetch_req, 0);
    end else begin
      n_refetch++;
      chk(refetch_req == 1'b1, "R8 refetch_req", refetch_req, 1);
      chk(fme_start == 1'b0, "R8 start held", fme_start, 0);
      tick();
      chk(refetch_req == 1'b1, "R8 req held", refetch_req, 1);
      refetch_ack = 1;
      tick();
      refetch_ack = 0;
      chk(fme_start == 1'b1, "R8 start after ack", fme_start, 1);
      chk(refetch_req == 1'b0, "R8 req cleared", refetch_req, 0);
    end
    chk(reuse_count == n_reuse, "R9 reuse_count", reuse_count, n_reuse);
    chk(refetch_count == n_refetch, "R9 refetch_count", refetch_count, n_refetch);
    tick();
    chk(fme_start == 1'b0, "R7 single pulse", fme_start, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; ime_done = 0; fme_done = 0; load_done = 0; refetch_ack = 0;
    ime_mv_x = 0; ime_mv_y = 0;
    @(negedge clk); tick(); tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk(ime_bank == 0 && fme_bank == 1 && load_bank == 2, "R1 banks", ime_bank, 0);
    chk(!ime_start && !load_req && !fme_start && !refetch_req && !fme_reuse, "R1 outputs", 1, 0);
    chk(reuse_count == 0 && refetch_count == 0, "R1 counters", reuse_count, 0);

    // Table walk: rotation, vector handover, verdicts, counters
    for (int v = 0; v < 8; v++) begin
      logic signed [7:0] vx, vy;
      logic er;
      vx = VEC[v][16:9]; vy = VEC[v][8:1]; er = VEC[v][0];
      pulse_done(1, 1, 1, vx, vy);   // flags now set, step visible
      tick();                        // rotation edge
      steps++;
      check_banks("R2 rotation");
      chk(ime_start && load_req, "R4 start pulses", ime_start, 1);
      chk(fme_mv_x == vx, "R5 mv x", fme_mv_x, vx);
      chk(fme_mv_y == vy, "R5 mv y", fme_mv_y, vy);
      chk(fme_reuse == er, "R6 verdict", fme_reuse, er);
      finish_macroblock(er);
      chk(!ime_start && !load_req, "R4 pulse ends", ime_start, 0);
    end

    // R3: two of three completions do not rotate
    pulse_done(1, 1, 0, 8'sd3, -8'sd4);
    repeat (5) tick();
    check_banks("R3 held without load_done");
    chk(ime_start == 1'b0, "R3 no start", ime_start, 0);
    pulse_done(0, 0, 1, 8'sd0, 8'sd0);
    tick();
    steps++;
    check_banks("R3 rotation after last done");
    chk(fme_mv_x == 3 && fme_mv_y == -4, "R5 mv held from ime_done", fme_mv_x, 3);
    finish_macroblock(1'b1);

    // R10: stray acknowledge while idle
    refetch_ack = 1;
    tick();
    refetch_ack = 0;
    chk(fme_start == 1'b0, "R10 no start from stray ack", fme_start, 0);
    chk(refetch_req == 1'b0, "R10 no request", refetch_req, 0);
    chk(refetch_count == n_refetch, "R10 counter untouched", refetch_count, n_refetch);

    // R8/R3: completions during a refetch wait are held
    pulse_done(1, 1, 1, 8'sd100, 8'sd0);
    tick();
    steps++;
    chk(fme_reuse == 1'b0, "R6 outside verdict", fme_reuse, 0);
    tick();
    n_refetch++;
    chk(refetch_req == 1'b1, "R8 request", refetch_req, 1);
    pulse_done(1, 1, 1, 8'sd1, 8'sd1);
    repeat (4) tick();
    check_banks("R8 no rotation while waiting");
    chk(refetch_req == 1'b1, "R8 still waiting", refetch_req, 1);
    refetch_ack = 1;
    tick();
    refetch_ack = 0;
    chk(fme_start == 1'b1, "R8 start after ack", fme_start, 1);
    tick();
    steps++;
    check_banks("R3 deferred rotation");
    chk(fme_mv_x == 1 && fme_mv_y == 1, "R5 deferred mv", fme_mv_x, 1);
    finish_macroblock(1'b1);
    chk(refetch_count == n_refetch, "R9 final refetch", refetch_count, n_refetch);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule